// File: doc/BRIEF.md
# Adaptive Guard-Time Gate Driver

This block sits between a digital ternary PWM source and the gate buffers of a full-bridge power stage. Each leg of the bridge receives one command bit (high side wanted or low side wanted). The block turns that bit into a pair of complementary gate signals. It never lets both transistors of a leg conduct together. Every change of side is separated by a fixed number of ticks with both devices off. The conducting time of each high-side pulse is widened by a guard time, which offsets the turn-off delay of the power devices.

The guard time is not a constant. A one-bit input carries the polarity of the load current. Each time a sample strobe arrives, that polarity nudges a pending guard value up or down by a fixed step, bounded by a programmable floor and ceiling. The pending value is handed to the legs only when a frame boundary strobe arrives. Each leg also freezes the guard it uses at the start of every pulse, so a retune never reshapes a pulse that is already under way. A command pulse too short to survive the dead interval is stretched to a minimum on-time, so the gate never sees a sliver pulse.

Top module: `guarded_gate_driver`

## Requirements
- R1: In no clock cycle are the high-side and low-side outputs of the same leg both 1.
- R2: When a leg changes side, the outgoing gate drops in the first cycle after the change is seen, and the incoming gate rises exactly DEAD_TICKS cycles later, with both gates 0 in between.
- R3: For a command high pulse of W cycles with W greater than DEAD_TICKS, the high-side gate stays on for W + G − DEAD_TICKS cycles, where G is the guard (in ticks) latched at the start of that pulse.
- R4: A high-side pulse always lasts at least MIN_ON cycles, even when R3 would give fewer.
- R5: A cycle with the sample strobe at 1 moves the pending guard up by GUARD_STEP ticks when the current-sign input is 1, and down by GUARD_STEP ticks when it is 0.
- R6: The pending guard never goes above the guard ceiling input or below the guard floor input; a step that would cross a bound stops at the bound.
- R7: A new pending guard changes pulse widths only after a cycle with the frame strobe at 1; before that, pulses keep the previous guard.
- R8: A frame strobe that arrives while a high-side pulse is on leaves that pulse's width unchanged; the new guard applies from the next pulse.
- R9: While reset is held, all gate outputs are 0; after release, each low-side gate rises DEAD_TICKS cycles later and the guard starts at GUARD_INIT.
- R10: A command on one leg has no effect on the gates of another leg.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; every time value is counted in its cycles |
| rstN | input | 1 | Active-low asynchronous reset |
| pwmIn | input | LEGS | Ternary PWM command per leg, 1 asks for the high side |
| signStrobe | input | 1 | One-cycle strobe that samples currentSign |
| currentSign | input | 1 | Polarity of the load current, 1 raises the guard |
| frameEdge | input | 1 | One-cycle strobe marking a PWM frame boundary |
| guardMin | input | GUARD_W | Floor of the guard value, in ticks |
| guardMax | input | GUARD_W | Ceiling of the guard value, in ticks |
| hiGate | output | LEGS | High-side gate drive per leg |
| loGate | output | LEGS | Low-side gate drive per leg |

## Verification
The bound checker watches each leg in every cycle. It checks that the two gates never overlap, that a gate never rises in the cycle right after its partner was on, and that no high-side pulse ends before the minimum on-time. The exact pulse widths, the dead intervals and the guard tuning can only be shown by the bench scenarios. Those scenarios cover the widening against the latched guard, clamping at both bounds, the deferral to a frame strobe and a strobe during a live pulse. Each one is measured at the gate pins.

// File: rtl/ggd_pkg.sv
`timescale 1ns/1ps
package ggd_pkg;
  localparam int GUARD_W = 5;

  typedef enum logic [1:0] {
    LEG_LO_ON = 2'd0,
    LEG_TO_HI = 2'd1,
    LEG_HI_ON = 2'd2,
    LEG_TO_LO = 2'd3
  } leg_state_e;

  // strobes from the guard control to every leg datapath
  typedef struct packed {
    logic               load;
    logic [GUARD_W-1:0] value;
  } guard_cmd_t;
endpackage

// File: rtl/ggd_guard_ctrl.sv
`timescale 1ns/1ps
module ggd_guard_ctrl
  import ggd_pkg::*;
#(
  parameter int GUARD_INIT = 6,
  parameter int GUARD_STEP = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               signStrobe,
  input  logic               currentSign,
  input  logic               frameEdge,
  input  logic [GUARD_W-1:0] guardMin,
  input  logic [GUARD_W-1:0] guardMax,
  output guard_cmd_t         gcmd
);
  localparam logic [GUARD_W:0]   STEP_WIDE = (GUARD_W+1)'(GUARD_STEP);
  localparam logic [GUARD_W-1:0] INIT_VAL  = GUARD_W'(GUARD_INIT);

  logic [GUARD_W-1:0] pending;
  logic [GUARD_W-1:0] nextPending;
  logic [GUARD_W:0]   raised;
  logic [GUARD_W:0]   floorPlusStep;

  always_comb begin
    raised        = {1'b0, pending} + STEP_WIDE;
    floorPlusStep = {1'b0, guardMin} + STEP_WIDE;
    nextPending   = pending;
    if (signStrobe) begin
      if (currentSign) begin
        if (raised > {1'b0, guardMax})      nextPending = guardMax;
        else if (raised < {1'b0, guardMin}) nextPending = guardMin;
        else                                nextPending = raised[GUARD_W-1:0];
      end else begin
        if ({1'b0, pending} < floorPlusStep) nextPending = guardMin;
        else if (pending - STEP_WIDE[GUARD_W-1:0] > guardMax) nextPending = guardMax;
        else nextPending = pending - STEP_WIDE[GUARD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= INIT_VAL;
    else       pending <= nextPending;
  end

  assign gcmd.load  = frameEdge;
  assign gcmd.value = pending;
endmodule

// File: rtl/ggd_leg.sv
`timescale 1ns/1ps
module ggd_leg
  import ggd_pkg::*;
#(
  parameter int DEAD_TICKS = 2,
  parameter int MIN_ON     = 4,
  parameter int GUARD_INIT = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmCmd,
  input  guard_cmd_t gcmd,
  output logic       hiOut,
  output logic       loOut
);
  localparam int DW = (DEAD_TICKS > 1) ? $clog2(DEAD_TICKS) : 1;
  localparam int MW = (MIN_ON > 1) ? $clog2(MIN_ON) : 1;
  localparam logic [DW-1:0] DEAD_LOAD = DW'(DEAD_TICKS - 1);
  localparam logic [MW-1:0] MIN_LOAD  = MW'(MIN_ON - 1);

  leg_state_e         state;
  logic [DW-1:0]      deadCnt;
  logic [MW-1:0]      minCnt;
  logic [GUARD_W-1:0] tailCnt;
  logic [GUARD_W-1:0] frameGuard;
  logic [GUARD_W-1:0] pulseGuard;

  // guard copy that only changes on a frame strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          frameGuard <= GUARD_W'(GUARD_INIT);
    else if (gcmd.load) frameGuard <= gcmd.value;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= LEG_TO_LO;
      deadCnt    <= DEAD_LOAD;
      minCnt     <= '0;
      tailCnt    <= '0;
      pulseGuard <= '0;
    end else begin
      unique case (state)
        LEG_LO_ON: begin
          if (pwmCmd) begin
            state   <= LEG_TO_HI;
            deadCnt <= DEAD_LOAD;
          end
        end
        LEG_TO_HI: begin
          if (deadCnt == '0) begin
            state      <= LEG_HI_ON;
            pulseGuard <= frameGuard;
            tailCnt    <= frameGuard;
            minCnt     <= MIN_LOAD;
          end else begin
            deadCnt <= deadCnt - 1'b1;
          end
        end
        LEG_HI_ON: begin
          if (minCnt != '0) minCnt <= minCnt - 1'b1;
          if (pwmCmd)              tailCnt <= pulseGuard;
          else if (tailCnt != '0)  tailCnt <= tailCnt - 1'b1;
          if (!pwmCmd && tailCnt == '0 && minCnt == '0) begin
            state   <= LEG_TO_LO;
            deadCnt <= DEAD_LOAD;
          end
        end
        LEG_TO_LO: begin
          if (deadCnt == '0) begin
            if (pwmCmd) begin
              state   <= LEG_TO_HI;
              deadCnt <= DEAD_LOAD;
            end else begin
              state <= LEG_LO_ON;
            end
          end else begin
            deadCnt <= deadCnt - 1'b1;
          end
        end
        default: state <= LEG_TO_LO;
      endcase
    end
  end

  assign hiOut = (state == LEG_HI_ON);
  assign loOut = (state == LEG_LO_ON);
endmodule

// File: rtl/guarded_gate_driver.sv
`timescale 1ns/1ps
module guarded_gate_driver
  import ggd_pkg::*;
#(
  parameter int LEGS       = 2,
  parameter int DEAD_TICKS = 2,
  parameter int MIN_ON     = 4,
  parameter int GUARD_INIT = 6,
  parameter int GUARD_STEP = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEGS-1:0]    pwmIn,
  input  logic               signStrobe,
  input  logic               currentSign,
  input  logic               frameEdge,
  input  logic [GUARD_W-1:0] guardMin,
  input  logic [GUARD_W-1:0] guardMax,
  output logic [LEGS-1:0]    hiGate,
  output logic [LEGS-1:0]    loGate
);
  guard_cmd_t gcmd;

  ggd_guard_ctrl #(
    .GUARD_INIT(GUARD_INIT),
    .GUARD_STEP(GUARD_STEP)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .signStrobe (signStrobe),
    .currentSign(currentSign),
    .frameEdge  (frameEdge),
    .guardMin   (guardMin),
    .guardMax   (guardMax),
    .gcmd       (gcmd)
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    ggd_leg #(
      .DEAD_TICKS(DEAD_TICKS),
      .MIN_ON    (MIN_ON),
      .GUARD_INIT(GUARD_INIT)
    ) u_leg (
      .clk   (clk),
      .rstN  (rstN),
      .pwmCmd(pwmIn[g]),
      .gcmd  (gcmd),
      .hiOut (hiGate[g]),
      .loOut (loGate[g])
    );
  end
endmodule

// File: rtl/ggd_checker.sv
`timescale 1ns/1ps
module ggd_checker #(
  parameter int LEGS   = 2,
  parameter int MIN_ON = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic [LEGS-1:0] hiGate,
  input logic [LEGS-1:0] loGate
);
  // R1: the two gates of a leg never conduct together
  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (hiGate & loGate) == '0);

  for (genvar g = 0; g < LEGS; g++) begin : g_chk
    logic [15:0] runLen;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  runLen <= '0;
      else if (!hiGate[g])        runLen <= '0;
      else if (runLen != 16'hFFFF) runLen <= runLen + 1'b1;
    end

    // R2: a gate only rises after a cycle in which its partner was off
    assert_dead_before_hi_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(hiGate[g]) |-> !$past(loGate[g]));
    assert_dead_before_lo_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(loGate[g]) |-> !$past(hiGate[g]));

    // R4: no high-side pulse shorter than the minimum on-time
    assert_min_on_R4: assert property (@(posedge clk) disable iff (!rstN)
      $fell(hiGate[g]) |-> (runLen >= 16'(MIN_ON)));
  end
endmodule

bind guarded_gate_driver ggd_checker #(
  .LEGS  (LEGS),
  .MIN_ON(MIN_ON)
) chk (
  .clk   (clk),
  .rstN  (rstN),
  .hiGate(hiGate),
  .loGate(loGate)
);

// File: tb/tb_guarded_gate_driver.sv
`timescale 1ns/1ps
module tb_guarded_gate_driver;
  import ggd_pkg::*;

  localparam int LEGS = 2;
  localparam int DEAD = 2;
  localparam int MINW = 4;

  // {command width, expected high-side width} with guard 6
  localparam int VEC [4][2] = '{'{10, 14}, '{20, 24}, '{5, 9}, '{3, 7}};

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [LEGS-1:0]    pwmIn = '0;
  logic               signStrobe = 1'b0;
  logic               currentSign = 1'b0;
  logic               frameEdge = 1'b0;
  logic [GUARD_W-1:0] guardMin = 5'd2;
  logic [GUARD_W-1:0] guardMax = 5'd10;
  logic [LEGS-1:0]    hiGate;
  logic [LEGS-1:0]    loGate;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  guarded_gate_driver #(
    .LEGS(LEGS), .DEAD_TICKS(DEAD), .MIN_ON(MINW), .GUARD_INIT(6), .GUARD_STEP(2)
  ) dut (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .signStrobe(signStrobe),
    .currentSign(currentSign), .frameEdge(frameEdge), .guardMin(guardMin),
    .guardMax(guardMax), .hiGate(hiGate), .loGate(loGate)
  );

  task automatic expectEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic strobeSign(input bit s);
    currentSign = s;
    signStrobe = 1'b1;
    @(negedge clk);
    signStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseFrame();
    frameEdge = 1'b1;
    @(negedge clk);
    frameEdge = 1'b0;
    @(negedge clk);
  endtask

  // command a pulse of w cycles on leg 0 and measure the gate response
  task automatic runPulse(input int w, input int expHi, input string req, input int frameAt);
    int hiN = 0, deadPre = 0, deadPost = 0, overlap = 0, otherLeg = 0;
    bit seenHi = 1'b0;
    pwmIn[0] = 1'b1;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (c == w - 1) pwmIn[0] = 1'b0;
      frameEdge = (c == frameAt);
      if (hiGate[0] && loGate[0]) overlap++;
      if (hiGate[0]) begin
        hiN++;
        seenHi = 1'b1;
      end else if (!loGate[0]) begin
        if (seenHi) deadPost++;
        else        deadPre++;
      end
      if (hiGate[1] || !loGate[1]) otherLeg++;
    end
    frameEdge = 1'b0;
    expectEq(req, "high-side width", hiN, expHi);
    expectEq("R2", "dead cycles before high side", deadPre, DEAD);
    expectEq("R2", "dead cycles before low side", deadPost, DEAD);
    expectEq("R1", "overlap cycles", overlap, 0);
    expectEq("R10", "disturbed cycles on leg 1", otherLeg, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    expectEq("R9", "gates during reset", int'({hiGate, loGate}), 0);
    rstN = 1'b1;
    @(negedge clk);
    expectEq("R9", "low gates one cycle after release", int'(loGate), 0);
    @(negedge clk);
    expectEq("R9", "low gates after dead interval", int'(loGate), 3);
    repeat (4) @(negedge clk);

    // R3: widening by the initial guard, table-driven
    for (int i = 0; i < 4; i++) runPulse(VEC[i][0], VEC[i][1], "R3", -1);

    // R7: pending guard 8 not yet applied
    strobeSign(1'b1);
    runPulse(10, 14, "R7", -1);
    // R5: after frame strobe guard 8 widens pulse
    pulseFrame();
    runPulse(10, 16, "R5", -1);
    // R6: two raises stop at ceiling 10
    strobeSign(1'b1);
    strobeSign(1'b1);
    pulseFrame();
    runPulse(10, 18, "R6", -1);
    // R8: lower to 8, frame strobe lands mid-pulse, width keeps guard 10
    strobeSign(1'b0);
    runPulse(10, 18, "R8", 4);
    // R5: lowered guard 8 now applies
    runPulse(10, 16, "R5", -1);
    // R6: floor 0, five lowers stop at 0
    guardMin = 5'd0;
    for (int i = 0; i < 5; i++) strobeSign(1'b0);
    pulseFrame();
    runPulse(10, 8, "R6", -1);
    // R4: short pulse stretched to minimum on-time
    runPulse(3, MINW, "R4", -1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule